// File: doc/BRIEF.md
# Noise Level Meter Accumulator

This block measures receive signal quality. On every symbol strobe it takes the magnitude of a signed slicer-error sample and adds it to an unsigned running total. A countdown timer splits the symbol stream into windows of programmable length. When a window closes, the total is copied into a readout register without any software action, and the running total restarts from zero.

Software sees only the top 16 bits of the readout, as two bytes on a byte-addressed bus with read and write strobes. Software must read the low byte first. That read also freezes the matching high byte in a shadow register, so the following high-byte read returns a value taken at the same moment, even if a window closes between the two reads. Any other access inside the meter address range cancels the pending pair.

Top module: `noise_meter`

## Requirements
- R1: After a synchronous reset, `bus_rdata` is 0, the readout is 0, no byte pair is pending, and the timer is loaded from `win_len`.
- R2: Each strobe with `sym_stb` high adds the absolute value of `err_smp` to the running total. The most negative sample counts as 2^(ERR_W-1).
- R3: On the strobe that finds the timer at zero, the readout takes the total including that symbol, and the running total restarts at zero.
- R4: When the timer is zero on a strobe, it reloads from `win_len`. Otherwise it counts down by one, so each window is `win_len`+1 strobes long.
- R5: The running total saturates at all ones instead of wrapping, so a saturated window reads 0xFF in both bytes.
- R6: A read of address 0x50 returns readout bits [7:0] of the visible 16 bits (total bits [ACC_W-9:ACC_W-16]). A read of 0x51 returns the visible bits [15:8] (total bits [ACC_W-1:ACC_W-8]). Each result is on `bus_rdata` in the cycle after the read strobe.
- R7: A read of 0x50 copies the current high byte into a shadow and marks a pair pending. The next read of 0x51 returns the shadow, even if the readout has changed since, and ends the pair.
- R8: A read or write anywhere in 0x40 to 0x5F, other than a read of 0x50 or 0x51, cancels a pending pair. A later read of 0x51 then returns the live high byte.
- R9: Accesses outside 0x40 to 0x5F leave a pending pair intact. Any read of an address other than 0x50 or 0x51 returns 0.
- R10: Cycles with `sym_stb` low change neither the total nor the timer. `bus_rdata` changes only on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle symbol-rate strobe |
| err_smp | input | ERR_W | Signed two's-complement slicer error |
| win_len | input | TMR_W | Window length minus one, in symbols |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (data is ignored) |
| bus_rdata | output | 8 | Registered read data |

## Verification
A read result is due on `bus_rdata` one clock after the cycle that carries `bus_rd`. A window close changes the readout on the strobe's own edge, so a read issued in the next cycle already sees the new value. The bench drives every input just after a falling edge. A behavioural model advances on the rising edge, and the bench compares `bus_rdata` with the model at the following falling edge. Directed checks use hand-computed byte values for window closing, reload, saturation and the pair rules, and a long random stretch mixes strobes with meter-range, out-of-range and pair accesses.

// File: rtl/nm_pkg.sv
package nm_pkg;
  // visible slice of the running total: two bytes
  localparam int NM_VIS_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_LO_RD = 2'd1,
    BUS_HI_RD = 2'd2,
    BUS_BREAK = 2'd3
  } bus_kind_e;
endpackage

// File: rtl/nm_mag.sv
module nm_mag #(
  parameter int ERR_W = 12
) (
  input  logic signed [ERR_W-1:0] err,
  output logic        [ERR_W-1:0] mag
);
  logic [ERR_W-1:0] err_u;

  always_comb begin
    err_u = err;
    if (err_u[ERR_W-1]) mag = ~err_u + {{(ERR_W-1){1'b0}}, 1'b1};
    else                mag = err_u;
  end

  always_comb begin
    AST_MAG_SIGN: assert (err_u[ERR_W-1] || (mag == err_u)); // R2
  end
endmodule

// File: rtl/nm_accum.sv
module nm_accum #(
  parameter int ERR_W = 12,
  parameter int ACC_W = 32,
  parameter int TMR_W = 16,
  parameter int VIS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [ERR_W-1:0] mag,
  input  logic [TMR_W-1:0] win_len,
  output logic [VIS_W-1:0] vis
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [TMR_W-1:0] tmr_q;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] sat;
  logic             win_end;

  always_comb begin
    sum     = {1'b0, acc_q} + {{(SUM_W-ERR_W){1'b0}}, mag};
    sat     = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    win_end = stb && (tmr_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tmr_q <= win_len;
      vis   <= '0;
    end else if (stb) begin
      if (win_end) begin
        vis   <= sat[ACC_W-1 -: VIS_W];
        acc_q <= '0;
        tmr_q <= win_len;
      end else begin
        acc_q <= sat;
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (acc_q == '0)); // R3
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (tmr_q == $past(win_len))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (stb && !win_end) |=> (acc_q >= $past(acc_q))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(acc_q) && $stable(tmr_q) && $stable(vis))); // R10
endmodule

// File: rtl/nm_regif.sv
module nm_regif
  import nm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int VIS_W   = 16,
  parameter int RNG_LO  = 'h40,
  parameter int RNG_HI  = 'h5F,
  parameter int LO_ADDR = 'h50,
  parameter int HI_ADDR = 'h51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [VIS_W-1:0]  live,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_RLO = ADDR_W'(RNG_LO);
  localparam logic [ADDR_W-1:0] A_RHI = ADDR_W'(RNG_HI);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(HI_ADDR);

  bus_kind_e  kind;
  logic       in_rng;
  logic       pend_q;
  logic [7:0] shadow_q;

  always_comb begin
    in_rng = (addr >= A_RLO) && (addr <= A_RHI);
    if (rd && addr == A_LO)           kind = BUS_LO_RD;
    else if (rd && addr == A_HI)      kind = BUS_HI_RD;
    else if ((rd || wr) && in_rng)    kind = BUS_BREAK;
    else                              kind = BUS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      shadow_q <= '0;
      rdata    <= '0;
    end else begin
      case (kind)
        BUS_LO_RD: begin
          rdata    <= live[7:0];
          shadow_q <= live[15:8];
          pend_q   <= 1'b1;
        end
        BUS_HI_RD: begin
          rdata  <= pend_q ? shadow_q : live[15:8];
          pend_q <= 1'b0;
        end
        BUS_BREAK: begin
          pend_q <= 1'b0;
          if (rd) rdata <= '0;
        end
        default: begin
          if (rd) rdata <= '0;
        end
      endcase
    end
  end

  AST_LO_ARM: assert property (@(posedge clk) disable iff (rst)
    (kind == BUS_LO_RD) |=> (pend_q && shadow_q == $past(live[15:8]))); // R7
  AST_HI_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (kind == BUS_HI_RD && pend_q) |=> (rdata == $past(shadow_q) && !pend_q)); // R7
  AST_PAIR_BREAK: assert property (@(posedge clk) disable iff (rst)
    (kind == BUS_BREAK) |=> !pend_q); // R8
  AST_OUTSIDE_KEEP: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && !in_rng) |=> (pend_q == $past(pend_q))); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R10
endmodule

// File: rtl/noise_meter.sv
module noise_meter
  import nm_pkg::*;
#(
  parameter int ERR_W   = 12,
  parameter int ACC_W   = 32,
  parameter int TMR_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int RNG_LO  = 'h40,
  parameter int RNG_HI  = 'h5F,
  parameter int LO_ADDR = 'h50,
  parameter int HI_ADDR = 'h51
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sym_stb,
  input  logic signed [ERR_W-1:0] err_smp,
  input  logic [TMR_W-1:0]        win_len,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  output logic [7:0]              bus_rdata
);
  localparam int VIS_W = NM_VIS_W;

  logic [ERR_W-1:0] mag;
  logic [VIS_W-1:0] vis;

  nm_mag #(.ERR_W(ERR_W)) u_mag (
    .err (err_smp),
    .mag (mag)
  );

  nm_accum #(
    .ERR_W (ERR_W),
    .ACC_W (ACC_W),
    .TMR_W (TMR_W),
    .VIS_W (VIS_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .stb     (sym_stb),
    .mag     (mag),
    .win_len (win_len),
    .vis     (vis)
  );

  nm_regif #(
    .ADDR_W  (ADDR_W),
    .VIS_W   (VIS_W),
    .RNG_LO  (RNG_LO),
    .RNG_HI  (RNG_HI),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .live  (vis),
    .rdata (bus_rdata)
  );

  initial begin
    AST_ACC_WIDER: assert (ACC_W > ERR_W + 1 && ACC_W >= VIS_W); // R5
  end
endmodule

// File: tb/sim_noise_meter.sv
module sim_noise_meter;
  localparam int CLK_NS = 10;
  localparam int ERR_W  = 12;
  localparam int ACC_W  = 20;
  localparam int TMR_W  = 16;
  localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    sym_stb = 1'b0;
  logic signed [ERR_W-1:0] err_smp = '0;
  logic [TMR_W-1:0]        win_len = '0;
  logic [7:0]              bus_addr = '0;
  logic                    bus_rd = 1'b0;
  logic                    bus_wr = 1'b0;
  logic [7:0]              bus_rdata;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  noise_meter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .TMR_W(TMR_W)) u0 (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .err_smp(err_smp),
    .win_len(win_len), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata)
  );

  // behavioural reference
  longint m_acc, m_snap, m_tmr;
  int     m_rd, m_sh;
  bit     m_pend;

  always @(posedge clk) begin
    longint mag, tot;
    int hi, lo, vis;
    if (rst) begin
      m_acc = 0; m_snap = 0; m_tmr = win_len; m_rd = 0; m_sh = 0; m_pend = 0;
    end else begin
      vis = int'(m_snap >> (ACC_W - 16));
      lo = vis & 255; hi = (vis >> 8) & 255;
      if (bus_rd) begin
        if (bus_addr == 8'h50) begin m_rd = lo; m_sh = hi; m_pend = 1; end
        else if (bus_addr == 8'h51) begin m_rd = m_pend ? m_sh : hi; m_pend = 0; end
        else begin
          m_rd = 0;
          if (bus_addr >= 8'h40 && bus_addr <= 8'h5F) m_pend = 0;
        end
      end else if (bus_wr && bus_addr >= 8'h40 && bus_addr <= 8'h5F) m_pend = 0;
      if (sym_stb) begin
        mag = longint'(err_smp);
        if (mag < 0) mag = -mag;
        tot = m_acc + mag;
        if (tot > ACC_MAX) tot = ACC_MAX;
        if (m_tmr == 0) begin m_snap = tot; m_acc = 0; m_tmr = win_len; end
        else begin m_acc = tot; m_tmr = m_tmr - 1; end
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, got, exp, $time);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input bit stb, input int err, input bit rd, input bit wr, input int addr);
    sym_stb = stb; err_smp = ERR_W'(err); bus_rd = rd; bus_wr = wr; bus_addr = 8'(addr);
    @(posedge clk);
    @(negedge clk);
    sym_stb = 0; bus_rd = 0; bus_wr = 0;
    chk(cur_req, int'(bus_rdata), m_rd);
  endtask

  task automatic strobe(input int err); step(1, err, 0, 0, 0); endtask
  task automatic rdb(input int addr); step(0, 0, 1, 0, addr); endtask

  task automatic do_reset(input int wl);
    win_len = TMR_W'(wl); rst = 1;
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    do_reset(0);
    chk("R1", int'(bus_rdata), 0);
    rdb(8'h50); chk("R1", int'(bus_rdata), 0);
    rdb(8'h51); chk("R1", int'(bus_rdata), 0);

    // one-symbol windows
    cur_req = "R2";
    strobe(-2048);
    rdb(8'h50); chk("R2 most negative", int'(bus_rdata), 8'h80);
    strobe(16);
    rdb(8'h50); chk("R3 restart", int'(bus_rdata), 8'h01);

    // four-symbol windows
    cur_req = "R4";
    win_len = 3;
    strobe(0);
    for (int i = 0; i < 3; i++) strobe(1600);
    rdb(8'h50); chk("R4 window open", int'(bus_rdata), 0);
    cur_req = "R10";
    for (int i = 0; i < 6; i++) step(0, -2048, 0, 0, 0);
    rdb(8'h50); chk("R10 idle", int'(bus_rdata), 0);
    cur_req = "R4";
    strobe(1600);
    rdb(8'h50); chk("R4 close lo", int'(bus_rdata), 8'h90);
    rdb(8'h51); chk("R6 close hi", int'(bus_rdata), 8'h01);

    // pair coherence
    cur_req = "R7";
    rdb(8'h50);
    for (int i = 0; i < 4; i++) strobe(-2048);
    rdb(8'h51); chk("R7 shadow", int'(bus_rdata), 8'h01);
    rdb(8'h51); chk("R7 live after pair", int'(bus_rdata), 8'h02);

    cur_req = "R8";
    rdb(8'h50);
    for (int i = 0; i < 4; i++) strobe(100);
    step(0, 0, 0, 1, 8'h5F);
    rdb(8'h51); chk("R8 write break", int'(bus_rdata), 8'h00);
    for (int i = 0; i < 4; i++) strobe(2048 - 1);
    rdb(8'h50);
    for (int i = 0; i < 4; i++) strobe(0);
    rdb(8'h45); chk("R9 unmapped read", int'(bus_rdata), 0);
    rdb(8'h51); chk("R8 read break", int'(bus_rdata), 8'h00);

    cur_req = "R9";
    for (int i = 0; i < 4; i++) strobe(-2048);
    rdb(8'h50);
    rdb(8'h80); chk("R9 outside read", int'(bus_rdata), 0);
    step(0, 0, 0, 1, 8'h10);
    for (int i = 0; i < 4; i++) strobe(100);
    rdb(8'h51); chk("R9 pair kept", int'(bus_rdata), 8'h02);

    // saturation
    cur_req = "R5";
    do_reset(1023);
    for (int i = 0; i < 1024; i++) strobe(-2048);
    rdb(8'h50); chk("R5 sat lo", int'(bus_rdata), 8'hFF);
    rdb(8'h51); chk("R5 sat hi", int'(bus_rdata), 8'hFF);

    // random mix
    cur_req = "R6";
    do_reset(7);
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      int e = $urandom_range(0, 4095) - 2048;
      case (k)
        0: step($urandom_range(0, 1) == 1, e, 1, 0, 8'h50);
        1: step($urandom_range(0, 1) == 1, e, 1, 0, 8'h51);
        2: step($urandom_range(0, 1) == 1, e, 1, 0, 8'h4A);
        3: step($urandom_range(0, 1) == 1, e, 0, 1, 8'h51);
        4: step($urandom_range(0, 1) == 1, e, 1, 0, 8'hC3);
        default: step($urandom_range(0, 2) != 0, e, 0, 0, 0);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule